// File: doc/BRIEF.md
# DMA Controller Register and Interrupt Front End

This block is the word-addressed register file of a multi-channel DMA controller. A host writes and reads it one word at a time. It holds a bank of five 32-bit registers for each channel: source address, destination address, next-descriptor pointer, control and configuration. It also holds a global configuration word and a synchronisation word. Every channel register and both global words drive output ports, so that the transfer engine beside this block can use them.

The engine reports a finished transfer or a bus error by pulsing one bit per channel. Those pulses set sticky raw flags, which software clears by writing ones. There is no separate mask register. Each channel's own configuration word enables its terminal-count interrupt with bit 15 and its error interrupt with bit 14. Three registered interrupt lines carry the masked error state, the masked terminal-count state and their OR.

A small read-only window returns a fixed eight-byte identification sequence. Its first byte tells the two-channel build apart from the others. The channel count is a parameter (8 or 2).

Top module: `dmac_csr`

## Requirements
- R1: After reset, every flag, the global configuration, the sync word and every channel register read as zero, and all three interrupt outputs are low.
- R2: Word address 0x40 | channel<<3 | reg reaches channel registers, with reg 0 source, 1 destination, 2 descriptor pointer, 3 control and 4 configuration. Each register reads back the last value written to it.
- R3: A write to register index 5, 6 or 7, or to a channel index at or above NCH, changes nothing, and such an address reads as zero.
- R4: A pulse on tc_set[i] or err_set[i] sets raw flag bit i. The flag stays set until it is cleared. Raw flags read at word 5 (terminal count) and word 6 (error).
- R5: Writing word 2 clears every terminal-count flag whose wdata bit is 1. Writing word 4 does the same for the error flags. Zero bits leave their flags unchanged.
- R6: When a set pulse and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R7: Channel i's terminal-count mask is its configuration bit 15 and its error mask is configuration bit 14. Word 1 reads the masked terminal-count flags, word 3 the masked error flags, and word 0 the bitwise OR of the two.
- R8: Word 7 reads a bitmap of configuration bit 0 (channel enable) across the channels.
- R9: Word addresses 0x3F8 to 0x3FF read, in order, 0x80 (0x81 when NCH is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05 and 0xB1 in the low byte.
- R10: Words 12 and 13 are read/write and drive dma_cfg and dma_sync. Words 8 to 11 ignore writes. Words 8 to 11, and every global or unmapped word not listed in R2, R4, R5, R7, R8, R9 or this requirement, read as zero.
- R11: irq_tc and irq_err go high one clock edge after the stored flags and masks produce any masked terminal-count or error bit. They fall one edge after that state goes away. irq_any is always their OR.
- R12: The ch_* output ports carry each channel's registers, with channel i in bits [32*i+31:32*i].

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for waddr/wdata |
| waddr | input | 10 | Word address (byte offset divided by 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for waddr, combinational |
| tc_set | input | NCH | Terminal-count set pulses from the engine |
| err_set | input | NCH | Error set pulses from the engine |
| ch_src | output | 32*NCH | Source address registers |
| ch_dst | output | 32*NCH | Destination address registers |
| ch_lli | output | 32*NCH | Next-descriptor pointer registers |
| ch_ctrl | output | 32*NCH | Control registers |
| ch_cfg | output | 32*NCH | Configuration registers |
| dma_cfg | output | 32 | Global configuration word |
| dma_sync | output | 32 | Synchronisation word |
| irq_err | output | 1 | Any masked error flag, registered |
| irq_tc | output | 1 | Any masked terminal-count flag, registered |
| irq_any | output | 1 | OR of irq_err and irq_tc |

## Verification
The engine's set pulses and a host write-one-to-clear can land on the same flag in the same clock. The bench provokes this by raising tc_set and err_set on the cycle that writes words 2 and 4 with all ones, on top of other flags that were set earlier. Reading words 5 and 6 afterwards must show only the freshly pulsed bits: the earlier flags were cleared, while the pulsed bits survived. The bench also tracks interrupt lines cycle by cycle around mask writes and clears, so that a one-edge lag that is missing or added shows up as a mismatch.

// File: rtl/dmac_csr.sv
module dmac_csr #(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [9:0]       waddr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NCH-1:0]   tc_set,
  input  logic [NCH-1:0]   err_set,
  output logic [NCH*32-1:0] ch_src,
  output logic [NCH*32-1:0] ch_dst,
  output logic [NCH*32-1:0] ch_lli,
  output logic [NCH*32-1:0] ch_ctrl,
  output logic [NCH*32-1:0] ch_cfg,
  output logic [31:0]      dma_cfg,
  output logic [31:0]      dma_sync,
  output logic             irq_err,
  output logic             irq_tc,
  output logic             irq_any
);

  localparam logic [7:0] ID_FIRST = (NCH == 2) ? 8'h81 : 8'h80;
  localparam int TC_MBIT  = 15;
  localparam int ERR_MBIT = 14;

  logic       chan_hit, glob_hit, id_hit;
  logic [2:0] csel, rsel;
  logic [5:0] gword;

  assign chan_hit = (waddr[9:6] == 4'd1);
  assign glob_hit = (waddr[9:6] == 4'd0);
  assign id_hit   = (waddr[9:3] == 7'h7F);
  assign csel     = waddr[5:3];
  assign rsel     = waddr[2:0];
  assign gword    = waddr[5:0];

  logic [31:0] src_q [NCH];
  logic [31:0] dst_q [NCH];
  logic [31:0] lli_q [NCH];
  logic [31:0] ctl_q [NCH];
  logic [31:0] cfg_ch_q [NCH];
  logic [NCH-1:0] tc_msk, err_msk, en_map;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wsel;
    assign wsel = wr_en && chan_hit && (csel == 3'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[g]    <= '0;
        dst_q[g]    <= '0;
        lli_q[g]    <= '0;
        ctl_q[g]    <= '0;
        cfg_ch_q[g] <= '0;
      end else if (wsel) begin
        case (rsel)
          3'd0: src_q[g]    <= wdata;
          3'd1: dst_q[g]    <= wdata;
          3'd2: lli_q[g]    <= wdata;
          3'd3: ctl_q[g]    <= wdata;
          3'd4: cfg_ch_q[g] <= wdata;
          default: ;
        endcase
      end
    end

    assign ch_src[g*32 +: 32]  = src_q[g];
    assign ch_dst[g*32 +: 32]  = dst_q[g];
    assign ch_lli[g*32 +: 32]  = lli_q[g];
    assign ch_ctrl[g*32 +: 32] = ctl_q[g];
    assign ch_cfg[g*32 +: 32]  = cfg_ch_q[g];
    assign tc_msk[g]  = cfg_ch_q[g][TC_MBIT];
    assign err_msk[g] = cfg_ch_q[g][ERR_MBIT];
    assign en_map[g]  = cfg_ch_q[g][0];
  end

  logic [NCH-1:0] tc_q, err_q, tc_clr, err_clr, tc_act, err_act;
  logic [31:0]    cfg_q, sync_q;
  logic           irq_tc_q, irq_err_q, irq_any_q;

  assign tc_clr  = (wr_en && glob_hit && gword == 6'd2) ? wdata[NCH-1:0] : '0;
  assign err_clr = (wr_en && glob_hit && gword == 6'd4) ? wdata[NCH-1:0] : '0;
  assign tc_act  = tc_q & tc_msk;
  assign err_act = err_q & err_msk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q      <= '0;
      err_q     <= '0;
      cfg_q     <= '0;
      sync_q    <= '0;
      irq_tc_q  <= 1'b0;
      irq_err_q <= 1'b0;
      irq_any_q <= 1'b0;
    end else begin
      tc_q      <= (tc_q & ~tc_clr) | tc_set;
      err_q     <= (err_q & ~err_clr) | err_set;
      irq_tc_q  <= |tc_act;
      irq_err_q <= |err_act;
      irq_any_q <= |(tc_act | err_act);
      if (wr_en && glob_hit && gword == 6'd12) cfg_q  <= wdata;
      if (wr_en && glob_hit && gword == 6'd13) sync_q <= wdata;
    end
  end

  assign dma_cfg  = cfg_q;
  assign dma_sync = sync_q;
  assign irq_tc   = irq_tc_q;
  assign irq_err  = irq_err_q;
  assign irq_any  = irq_any_q;

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = ID_FIRST;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h0A;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    rdata = '0;
    if (id_hit) begin
      rdata = {24'b0, id_byte(rsel)};
    end else if (chan_hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (csel == 3'(i)) begin
          case (rsel)
            3'd0: rdata = src_q[i];
            3'd1: rdata = dst_q[i];
            3'd2: rdata = lli_q[i];
            3'd3: rdata = ctl_q[i];
            3'd4: rdata = cfg_ch_q[i];
            default: rdata = '0;
          endcase
        end
      end
    end else if (glob_hit) begin
      case (gword)
        6'd0:  rdata = 32'(tc_act | err_act);
        6'd1:  rdata = 32'(tc_act);
        6'd3:  rdata = 32'(err_act);
        6'd5:  rdata = 32'(tc_q);
        6'd6:  rdata = 32'(err_q);
        6'd7:  rdata = 32'(en_map);
        6'd12: rdata = cfg_q;
        6'd13: rdata = sync_q;
        default: rdata = '0;
      endcase
    end
  end

  // R11
  any_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_tc || irq_err));

  // R11
  tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tc) |-> $past(tc_q != '0));

  // R6
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));

  // R6
  err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set)));

  // R5
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && glob_hit && gword == 6'd2) |=> ((tc_q & $past(wdata[NCH-1:0] & ~tc_set)) == '0));

  // R3
  reserved_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_hit && rsel > 3'd4) |-> (rdata == '0));

endmodule

// File: tb/dmac_csr_test.sv
module dmac_csr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [9:0] waddr = '0;
  logic [31:0] wdata = '0;
  logic [7:0] tc_set = '0, err_set = '0;
  logic [31:0] rdata, rdata2, dma_cfg, dma_sync, dma_cfg2, dma_sync2;
  logic [255:0] ch_src, ch_dst, ch_lli, ch_ctrl, ch_cfg;
  logic [63:0] c2_src, c2_dst, c2_lli, c2_ctrl, c2_cfg;
  logic irq_err, irq_tc, irq_any, i2_err, i2_tc, i2_any;

  int total = 0, bad = 0;
  int q_kind[$];
  logic [31:0] q_exp[$];
  string q_tag[$];

  always #2 clk = ~clk;

  dmac_csr #(.NCH(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata), .rdata(rdata),
    .tc_set(tc_set), .err_set(err_set), .ch_src(ch_src), .ch_dst(ch_dst), .ch_lli(ch_lli),
    .ch_ctrl(ch_ctrl), .ch_cfg(ch_cfg), .dma_cfg(dma_cfg), .dma_sync(dma_sync),
    .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any));

  dmac_csr #(.NCH(2)) uut2 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(wdata), .rdata(rdata2),
    .tc_set(tc_set[1:0]), .err_set(err_set[1:0]), .ch_src(c2_src), .ch_dst(c2_dst),
    .ch_lli(c2_lli), .ch_ctrl(c2_ctrl), .ch_cfg(c2_cfg), .dma_cfg(dma_cfg2),
    .dma_sync(dma_sync2), .irq_err(i2_err), .irq_tc(i2_tc), .irq_any(i2_any));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q_kind.size() > 0) begin
      int k;
      logic [31:0] e, a;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = (k == 0) ? rdata : (k == 1) ? rdata2 : {29'b0, irq_any, irq_tc, irq_err};
      chk(a, e, t);
    end
  end

  task automatic push(input int k, input logic [31:0] e, input string tag);
    q_kind.push_back(k);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    #1;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    waddr = a;
    push(0, e, tag);
  endtask

  task automatic rd2(input logic [9:0] a, input logic [31:0] e, input string tag);
    waddr = a;
    push(1, e, tag);
  endtask

  // expected bits {any, tc, err}
  task automatic irq(input logic [2:0] e, input string tag);
    push(2, {29'b0, e}, tag);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; waddr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] e);
    @(posedge clk); #1;
    tc_set = t; err_set = e;
    @(posedge clk); #1;
    tc_set = '0; err_set = '0;
  endtask

  localparam logic [7:0] IDB [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(10'd5, 0, "R1 raw tc");
    rd(10'd6, 0, "R1 raw err");
    rd(10'd12, 0, "R1 cfg");
    rd(10'h44, 0, "R1 ch0 cfg");
    irq(3'b000, "R1 irq");

    wr(10'h58, 32'hA5A50003);
    wr(10'h59, 32'h12340000);
    wr(10'h5A, 32'h00000011);
    wr(10'h5B, 32'h800000FF);
    rd(10'h58, 32'hA5A50003, "R2 src");
    rd(10'h59, 32'h12340000, "R2 dst");
    rd(10'h5A, 32'h00000011, "R2 lli");
    rd(10'h5B, 32'h800000FF, "R2 ctrl");
    chk(ch_src[3*32 +: 32], 32'hA5A50003, "R12 src port");
    chk(ch_ctrl[3*32 +: 32], 32'h800000FF, "R12 ctrl port");

    wr(10'h5D, 32'hFFFFFFFF);
    rd(10'h5D, 0, "R3 reg5 reads zero");
    rd(10'h58, 32'hA5A50003, "R3 neighbour kept");
    rd2(10'h58, 0, "R3 chan3 absent in 2ch");
    chk(c2_src, 64'h0, "R3 2ch ports untouched");

    wr(10'h44, 32'h1);
    wr(10'h5C, 32'h1);
    rd(10'd7, 32'h09, "R8 enable map");

    pulse(8'h0F, 8'h00);
    rd(10'd5, 32'h0F, "R4 raw tc");
    rd(10'd6, 0, "R4 raw err");
    rd(10'd1, 0, "R7 masked tc off");
    irq(3'b000, "R11 no mask");

    wr(10'h44, 32'h8001);
    irq(3'b000, "R11 lag");
    irq(3'b110, "R11 tc up");
    rd(10'd1, 32'h01, "R7 masked tc");
    rd(10'd0, 32'h01, "R7 combined");
    rd(10'd3, 0, "R7 masked err");

    pulse(8'h00, 8'h02);
    rd(10'd6, 32'h02, "R4 raw err");
    rd(10'd3, 0, "R7 err unmasked");
    wr(10'h4C, 32'h4000);
    irq(3'b110, "R11 err lag");
    irq(3'b111, "R11 err up");
    rd(10'd3, 32'h02, "R7 masked err");
    rd(10'd0, 32'h03, "R7 combined or");

    wr(10'd2, 32'h1);
    irq(3'b111, "R11 tc clear lag");
    irq(3'b101, "R11 tc down");
    rd(10'd5, 32'h0E, "R5 tc clear one bit");
    wr(10'd4, 32'h2);
    irq(3'b101, "R11 err clear lag");
    irq(3'b000, "R11 all down");
    rd(10'd6, 0, "R5 err clear");

    @(posedge clk); #1;
    wr_en = 1'b1; waddr = 10'd2; wdata = 32'hFF; tc_set = 8'h01;
    @(posedge clk); #1;
    waddr = 10'd4; wdata = 32'hFF; tc_set = 8'h00; err_set = 8'h04;
    @(posedge clk); #1;
    wr_en = 1'b0; err_set = 8'h00;
    rd(10'd5, 32'h01, "R6 tc set wins");
    rd(10'd6, 32'h04, "R6 err set wins");
    wr(10'd2, 32'hFF);
    wr(10'd4, 32'hFF);
    rd(10'd5, 0, "R5 tc all clear");
    rd(10'd6, 0, "R5 err all clear");

    for (int i = 0; i < 8; i++) rd(10'h3F8 + 10'(i), {24'b0, IDB[i]}, "R9 id byte");
    rd2(10'h3F8, 32'h81, "R9 2ch id");
    rd2(10'h3FF, 32'hB1, "R9 2ch last");

    wr(10'd12, 32'h7);
    rd(10'd12, 32'h7, "R10 cfg");
    chk(dma_cfg, 32'h7, "R10 cfg port");
    wr(10'd13, 32'hFFFF);
    rd(10'd13, 32'hFFFF, "R10 sync");
    chk(dma_sync, 32'hFFFF, "R10 sync port");
    wr(10'd9, 32'hFFFFFFFF);
    for (int i = 8; i < 12; i++) rd(10'(i), 0, "R10 words 8-11");
    rd(10'd14, 0, "R10 unlisted");
    rd(10'h080, 0, "R10 unmapped");

    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule